// File: doc/BRIEF.md
# Two-Phase Instruction Decoder

This block turns a 12-bit instruction word into the control signals of a small accumulator machine. Each instruction takes two clock cycles: an execute phase followed by a store phase. In the execute phase the decoder picks the source operand. That operand is either a register put on the data bus or the immediate field driven onto it. In the store phase it selects the destination register that takes the result. Alongside that it drives the ALU operation code, the jump condition code, port read and write strobes, and the write enable of the flags register. The ALU, the register file and the program-counter datapath sit outside. They only consume these controls.

The phase comes from a two-state machine inside the block. Its states are `PH_EXEC` and `PH_STORE`. Reset puts it in `PH_EXEC`. Every clock takes the transition `PH_EXEC -> PH_STORE` or `PH_STORE -> PH_EXEC`. The instruction input is held steady for the whole pair of cycles that starts in `PH_EXEC`. Five formats are told apart by the top three bits: ALU-with-register, short jump, far jump, copy-immediate and ALU-with-immediate. A 3-bit register code is also turned into a one-hot strobe, one bit per architectural register.

Top module: `twophase_idec`

## Requirements
- R1: After reset `phase_o` is 0 (`PH_EXEC`). On every clock it toggles, so 1 means `PH_STORE`.
- R2: Bits 11..9 pick the format: `00x` ALU-with-register, `01x` short jump, `10x` far jump, `110` copy-immediate, `111` ALU-with-immediate.
- R3: Register codes are PORT=000, ACCU=001, A=011, B=010, C=111, D=110, E=100, FLAGS=101. `reg_hit_o` has bit 0 PORT, 1 ACCU, 2 A, 3 B, 4 C, 5 D, 6 E, 7 FLAGS. It is one-hot at the code on `reg_sel_o` while `reg_en_o` is 1, and all zero otherwise.
- R4: ALU-with-register: `alu_op_o` is bits 9..6. In `PH_EXEC` the source field, bits 2..0, is selected and enabled. In `PH_STORE` the destination field, bits 5..3, is selected and enabled.
- R5: Copy-immediate: `alu_op_o` is 1000 (pass operand B). No register is enabled in `PH_EXEC`. In `PH_STORE` bits 8..6 are selected and enabled.
- R6: ALU-with-immediate: `alu_op_o` is 0 followed by bits 8..6. No register is enabled in `PH_EXEC`. In `PH_STORE` ACCU (001) is selected and enabled.
- R7: Short and far jumps enable no register in either phase and give `alu_op_o` = 1000. `cond_o` carries bits 9..6 for every format.
- R8: For an ALU operation whose code is compare (0110) or test (0111), in either ALU format, `reg_en_o` is 0 in `PH_STORE`.
- R9: Whenever `reg_en_o` is 0, `reg_sel_o` rests at 100.
- R10: `imm_o` always carries bits 5..0. `imm_en_o` is 1 in `PH_EXEC` for every format except ALU-with-register, and is 0 otherwise.
- R11: `port_rd_o` is 1 in both phases when an ALU-with-register instruction has source code 000. Otherwise it is 0.
- R12: `port_wr_o` is 1 in both phases in two cases. The first is an ALU-with-register instruction with destination code 000 whose operation is not compare or test. The second is a copy-immediate with destination code 000. Otherwise it is 0.
- R13: `flag_we_o` is 1 only in `PH_STORE` of an ALU-with-register instruction whose destination code is not 101, or of any ALU-with-immediate instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_i | input | 2*DATA_W | Instruction word, held for a full phase pair |
| phase_o | output | 1 | 0 execute phase, 1 store phase |
| reg_sel_o | output | 3 | Register code selected onto the data bus |
| reg_en_o | output | 1 | Selected register is active |
| reg_hit_o | output | 8 | One-hot register strobe |
| alu_op_o | output | 4 | ALU operation code |
| imm_en_o | output | 1 | Drive immediate field onto the data bus |
| imm_o | output | DATA_W | Immediate field |
| cond_o | output | 4 | Jump condition code |
| port_rd_o | output | 1 | Port read strobe for the instruction |
| port_wr_o | output | 1 | Port write strobe for the instruction |
| flag_we_o | output | 1 | Load flags register from ALU flags |

## Verification
The bench builds the block with the default `DATA_W` of 6. At that width the field positions are exactly those in the requirements, and the full 4096-word instruction space is reachable from random draws. That space covers every format, every register code in each operand field and all sixteen ALU codes. Directed words add the corners that random draws hit only rarely: the port as both source and destination, compare and test aimed at the port or at FLAGS, and the immediate-form compare. Each of these words is checked in both phases.

// File: rtl/idec_pkg.sv
package idec_pkg;

    typedef enum logic {
        PH_EXEC  = 1'b0,
        PH_STORE = 1'b1
    } phase_e;

    typedef enum logic [2:0] {
        FMT_ALU_REG,
        FMT_JMP_NEAR,
        FMT_JMP_FAR,
        FMT_COPY_IMM,
        FMT_ALU_IMM
    } fmt_e;

    localparam int SEL_W    = 3;
    localparam int OP_W     = 4;
    localparam int NUM_REGS = 8;

    localparam logic [SEL_W-1:0] RC_PORT  = 3'b000;
    localparam logic [SEL_W-1:0] RC_ACCU  = 3'b001;
    localparam logic [SEL_W-1:0] RC_A     = 3'b011;
    localparam logic [SEL_W-1:0] RC_B     = 3'b010;
    localparam logic [SEL_W-1:0] RC_C     = 3'b111;
    localparam logic [SEL_W-1:0] RC_D     = 3'b110;
    localparam logic [SEL_W-1:0] RC_E     = 3'b100;
    localparam logic [SEL_W-1:0] RC_FLAGS = 3'b101;

    localparam logic [OP_W-1:0] OP_PASS_B = 4'b1000;
    localparam logic [OP_W-1:0] OP_CMP    = 4'b0110;
    localparam logic [OP_W-1:0] OP_TEST   = 4'b0111;

    // Logical register index (strobe bit) to its 3-bit code.
    function automatic logic [SEL_W-1:0] reg_code(input int idx);
        logic [SEL_W-1:0] c;
        case (idx)
            0:       c = RC_PORT;
            1:       c = RC_ACCU;
            2:       c = RC_A;
            3:       c = RC_B;
            4:       c = RC_C;
            5:       c = RC_D;
            6:       c = RC_E;
            default: c = RC_FLAGS;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/idec_phase_fsm.sv
module idec_phase_fsm
    import idec_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    output phase_e phase_o
);

    phase_e st_q;
    phase_e st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= PH_EXEC;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            PH_EXEC:  st_d = PH_STORE;
            PH_STORE: st_d = PH_EXEC;
        endcase
    end

    assign phase_o = st_q;

    // R1: execute is always followed by store and store by execute
    assert_exec_to_store_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PH_EXEC) |=> (st_q == PH_STORE));
    assert_store_to_exec_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PH_STORE) |=> (st_q == PH_EXEC));

endmodule

// File: rtl/idec_format.sv
module idec_format
    import idec_pkg::*;
(
    input  logic [2:0] top_i,
    output fmt_e       fmt_o
);

    // R2: format from the three most significant instruction bits
    always_comb begin
        fmt_o = FMT_ALU_REG;
        unique casez (top_i)
            3'b00?: fmt_o = FMT_ALU_REG;
            3'b01?: fmt_o = FMT_JMP_NEAR;
            3'b10?: fmt_o = FMT_JMP_FAR;
            3'b110: fmt_o = FMT_COPY_IMM;
            3'b111: fmt_o = FMT_ALU_IMM;
        endcase
    end

endmodule

// File: rtl/idec_regmap.sv
module idec_regmap
    import idec_pkg::*;
(
    input  logic                en_i,
    input  logic [SEL_W-1:0]    code_i,
    output logic [NUM_REGS-1:0] hit_o
);

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_hit
        assign hit_o[g] = en_i && (code_i == reg_code(g));
    end

endmodule

// File: rtl/idec_ctrl.sv
module idec_ctrl
    import idec_pkg::*;
#(
    parameter int DATA_W = 6
) (
    input  phase_e                   phase_i,
    input  fmt_e                     fmt_i,
    input  logic [DATA_W+OP_W-1:0]   low_i,
    output logic [SEL_W-1:0]         reg_sel_o,
    output logic                     reg_en_o,
    output logic [OP_W-1:0]          alu_op_o,
    output logic                     imm_en_o,
    output logic [OP_W-1:0]          cond_o,
    output logic                     port_rd_o,
    output logic                     port_wr_o,
    output logic                     flag_we_o
);

    localparam int SHORT_OP_W = OP_W - 1;

    logic [SEL_W-1:0]      src_f;
    logic [SEL_W-1:0]      dst_f;
    logic [SEL_W-1:0]      cdst_f;
    logic [OP_W-1:0]       op_f;
    logic [OP_W-1:0]       op_short;
    logic                  reg_nosave;
    logic                  imm_nosave;
    logic                  in_store;

    assign src_f      = low_i[SEL_W-1:0];
    assign dst_f      = low_i[2*SEL_W-1:SEL_W];
    assign cdst_f     = low_i[DATA_W+SEL_W-1:DATA_W];
    assign op_f       = low_i[DATA_W+OP_W-1:DATA_W];
    assign op_short   = {1'b0, low_i[DATA_W+SHORT_OP_W-1:DATA_W]};
    assign reg_nosave = (op_f == OP_CMP) || (op_f == OP_TEST);
    assign imm_nosave = (op_short == OP_CMP) || (op_short == OP_TEST);
    assign in_store   = (phase_i == PH_STORE);
    assign cond_o     = op_f;

    always_comb begin
        reg_sel_o = RC_E;
        reg_en_o  = 1'b0;
        alu_op_o  = OP_PASS_B;
        imm_en_o  = 1'b0;
        port_rd_o = 1'b0;
        port_wr_o = 1'b0;
        flag_we_o = 1'b0;
        unique case (fmt_i)
            FMT_ALU_REG: begin
                alu_op_o  = op_f;
                port_rd_o = (src_f == RC_PORT);
                port_wr_o = (dst_f == RC_PORT) && !reg_nosave;
                flag_we_o = in_store && (dst_f != RC_FLAGS);
                if (!in_store) begin
                    reg_sel_o = src_f;
                    reg_en_o  = 1'b1;
                end else if (!reg_nosave) begin
                    reg_sel_o = dst_f;
                    reg_en_o  = 1'b1;
                end
            end
            FMT_ALU_IMM: begin
                alu_op_o  = op_short;
                imm_en_o  = !in_store;
                flag_we_o = in_store;
                if (in_store && !imm_nosave) begin
                    reg_sel_o = RC_ACCU;
                    reg_en_o  = 1'b1;
                end
            end
            FMT_COPY_IMM: begin
                imm_en_o  = !in_store;
                port_wr_o = (cdst_f == RC_PORT);
                if (in_store) begin
                    reg_sel_o = cdst_f;
                    reg_en_o  = 1'b1;
                end
            end
            FMT_JMP_NEAR, FMT_JMP_FAR: begin
                imm_en_o = !in_store;
            end
            default: begin
                imm_en_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/twophase_idec.sv
module twophase_idec
    import idec_pkg::*;
#(
    parameter int DATA_W = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [2*DATA_W-1:0]   instr_i,
    output logic                  phase_o,
    output logic [2:0]            reg_sel_o,
    output logic                  reg_en_o,
    output logic [7:0]            reg_hit_o,
    output logic [3:0]            alu_op_o,
    output logic                  imm_en_o,
    output logic [DATA_W-1:0]     imm_o,
    output logic [3:0]            cond_o,
    output logic                  port_rd_o,
    output logic                  port_wr_o,
    output logic                  flag_we_o
);

    localparam int INSTR_W = 2 * DATA_W;
    localparam int LOW_W   = DATA_W + OP_W;

    phase_e ph;
    fmt_e   fmt;

    idec_phase_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase_o (ph)
    );

    idec_format u_fmt (
        .top_i (instr_i[INSTR_W-1:INSTR_W-3]),
        .fmt_o (fmt)
    );

    idec_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .phase_i   (ph),
        .fmt_i     (fmt),
        .low_i     (instr_i[LOW_W-1:0]),
        .reg_sel_o (reg_sel_o),
        .reg_en_o  (reg_en_o),
        .alu_op_o  (alu_op_o),
        .imm_en_o  (imm_en_o),
        .cond_o    (cond_o),
        .port_rd_o (port_rd_o),
        .port_wr_o (port_wr_o),
        .flag_we_o (flag_we_o)
    );

    idec_regmap u_map (
        .en_i   (reg_en_o),
        .code_i (reg_sel_o),
        .hit_o  (reg_hit_o)
    );

    assign phase_o = (ph == PH_STORE);
    assign imm_o   = instr_i[DATA_W-1:0];

    // R3: strobe is one-hot exactly while a register is enabled
    assert_hit_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(reg_hit_o) == (reg_en_o ? 1 : 0));

    // R5: copy-immediate always passes operand B through the ALU
    assert_copy_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt == FMT_COPY_IMM) |-> (alu_op_o == OP_PASS_B));

    // R7: jumps never enable a register
    assert_jump_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt == FMT_JMP_NEAR || fmt == FMT_JMP_FAR) |-> (!reg_en_o && alu_op_o == OP_PASS_B));

    // R9: idle register select
    assert_idle_sel_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_en_o |-> (reg_sel_o == RC_E));

    // R10: immediate is driven only in the execute phase
    assert_imm_exec_R10: assert property (@(posedge clk) disable iff (!rst_n)
        imm_en_o |-> (ph == PH_EXEC));

    // R11: port read strobe spans the whole instruction
    assert_rd_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ph == PH_STORE && $stable(instr_i)) |-> $stable(port_rd_o));

    // R12: port write strobe spans the whole instruction
    assert_wr_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (ph == PH_STORE && $stable(instr_i)) |-> $stable(port_wr_o));

    // R13: flags are loaded only in the store phase
    assert_flag_store_R13: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we_o |-> (ph == PH_STORE));

endmodule

// File: tb/twophase_idec_bench.sv
`timescale 1ns/1ps
module twophase_idec_bench;

    localparam int DW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [11:0]   instr = '0;
    logic          phase_o, reg_en_o, imm_en_o, port_rd_o, port_wr_o, flag_we_o;
    logic [2:0]    reg_sel_o;
    logic [7:0]    reg_hit_o;
    logic [3:0]    alu_op_o, cond_o;
    logic [DW-1:0] imm_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    twophase_idec #(.DATA_W(DW)) u_twophase_idec (
        .clk(clk), .rst_n(rst_n), .instr_i(instr), .phase_o(phase_o),
        .reg_sel_o(reg_sel_o), .reg_en_o(reg_en_o), .reg_hit_o(reg_hit_o),
        .alu_op_o(alu_op_o), .imm_en_o(imm_en_o), .imm_o(imm_o), .cond_o(cond_o),
        .port_rd_o(port_rd_o), .port_wr_o(port_wr_o), .flag_we_o(flag_we_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s instr=%03h actual=%0h expected=%0h", tag, instr, act, exp);
        end
    endtask

    function automatic int strobe_bit(input logic [2:0] c);
        case (c)
            3'b000:  return 0;
            3'b001:  return 1;
            3'b011:  return 2;
            3'b010:  return 3;
            3'b111:  return 4;
            3'b110:  return 5;
            3'b100:  return 6;
            default: return 7;
        endcase
    endfunction

    task automatic verify(input logic [11:0] w, input bit st);
        logic [2:0] e_sel;
        bit         e_en, e_imm, e_rd, e_wr, e_fwe;
        logic [3:0] e_op;
        logic [7:0] e_hit;
        string      ftag;
        bit         nosave;
        e_sel = 3'b100; e_en = 0; e_imm = 0; e_rd = 0; e_wr = 0; e_fwe = 0;
        e_op = 4'b1000;
        if (w[11:10] == 2'b00) begin
            ftag = "R2/R4";
            e_op = w[9:6];
            nosave = (e_op == 4'b0110) || (e_op == 4'b0111);
            e_rd = (w[2:0] == 3'b000);
            e_wr = (w[5:3] == 3'b000) && !nosave;
            e_fwe = st && (w[5:3] != 3'b101);
            if (!st) begin e_sel = w[2:0]; e_en = 1; end
            else if (!nosave) begin e_sel = w[5:3]; e_en = 1; end
            else ftag = "R8";
        end else if (w[11:9] == 3'b111) begin
            ftag = "R2/R6";
            e_op = {1'b0, w[8:6]};
            nosave = (e_op == 4'b0110) || (e_op == 4'b0111);
            e_imm = !st;
            e_fwe = st;
            if (st && !nosave) begin e_sel = 3'b001; e_en = 1; end
            else if (st) ftag = "R8";
        end else if (w[11:9] == 3'b110) begin
            ftag = "R2/R5";
            e_imm = !st;
            e_wr = (w[8:6] == 3'b000);
            if (st) begin e_sel = w[8:6]; e_en = 1; end
        end else begin
            ftag = "R2/R7";
            e_imm = !st;
        end
        e_hit = e_en ? (8'b1 << strobe_bit(e_sel)) : 8'h00;
        check("R1 phase", phase_o, st);
        check({ftag, " reg_en"}, reg_en_o, e_en);
        check(e_en ? {ftag, " reg_sel"} : "R9 reg_sel", reg_sel_o, e_sel);
        check("R3 reg_hit", reg_hit_o, e_hit);
        check({ftag, " alu_op"}, alu_op_o, e_op);
        check("R7 cond", cond_o, w[9:6]);
        check("R10 imm_en", imm_en_o, e_imm);
        check("R10 imm", imm_o, w[5:0]);
        check("R11 port_rd", port_rd_o, e_rd);
        check("R12 port_wr", port_wr_o, e_wr);
        check("R13 flag_we", flag_we_o, e_fwe);
    endtask

    // Entered at a falling edge in the execute phase; leaves at the next one.
    task automatic run_one(input logic [11:0] w);
        instr = w;
        #1; verify(w, 1'b0);
        @(negedge clk); #1; verify(w, 1'b1);
        @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd1357));
        @(negedge clk); #1;
        check("R1 reset phase", phase_o, 0);
        @(negedge clk); #1;
        check("R1 reset phase held", phase_o, 0);
        @(negedge clk);
        rst_n = 1'b1;
        // directed corners
        run_one({2'b00, 4'b0000, 3'b010, 3'b011});   // R4 add B <- A
        run_one({2'b00, 4'b0101, 3'b111, 3'b000});   // R11 read port
        run_one({2'b00, 4'b0110, 3'b000, 3'b110});   // R8 R12 compare to port
        run_one({2'b00, 4'b0111, 3'b101, 3'b001});   // R8 R13 test into FLAGS
        run_one({2'b00, 4'b1101, 3'b101, 3'b100});   // R13 shift into FLAGS
        run_one({2'b00, 4'b1000, 3'b000, 3'b000});   // R11 R12 port both
        run_one({3'b110, 3'b000, 6'b101010});        // R5 R12 copy to port
        run_one({3'b110, 3'b101, 6'b111111});        // R5 copy to FLAGS
        run_one({3'b111, 3'b010, 6'b000111});        // R6 subtract immediate
        run_one({3'b111, 3'b110, 6'b000001});        // R6 R8 compare immediate
        run_one({2'b01, 4'b0111, 6'b110011});        // R7 short jump
        run_one({2'b10, 4'b1111, 6'b000000});        // R7 far jump
        for (int i = 0; i < 600; i++) run_one(12'($urandom));
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule